// File: doc/BRIEF.md
# Addressed Chip-Enable Serial Command Port

This block is the host-facing slave port of a segment display controller. A host drives three wires into it: chip enable, a serial clock and a data line. It gets back one open-drain data line, shown here as an active-low drive enable. Each transfer starts with an eight-bit address, shifted in while chip enable is low. Chip enable is then raised and the payload follows. One address writes half of the display and control image. Another address reads back the key matrix state plus a sleep flag. The serial clock may rest either high or low between transfers.

All three wires are oversampled by the system clock through a synchronizer. A write payload is gathered into a holding register. It reaches the outputs only when chip enable falls, and only if the frame had exactly the expected length and a valid half code. The block also holds a power-up reset flag for the rest of the chip. That flag clears on the first commit that leaves both halves of the image loaded. The image and control latches are never cleared, so writes land even while that flag is still set. The key scanner and the glass drive timing sit downstream and are not part of this block.

Top module: `serial_cmd_port`

## Requirements
- R1: The address is the last eight bits sampled on rising serial-clock edges while chip enable is low, with the first of those eight being bit 0. It is decoded when chip enable rises.
- R2: Address 0x42 opens a write frame and 0x43 opens a read frame. Any other address leaves every latch unchanged and keeps the data-out line released for the whole transfer.
- R3: A write frame is 56 bits, sampled on rising serial-clock edges while chip enable is high. It is committed on the fall of chip enable only if exactly 56 bits arrived. A shorter or longer frame is discarded.
- R4: In the first-half frame, received bits 1..39 go to disp_o[0..38]. Bits 40..45 are padding. Bits 46..54 carry, in order: sleep bit 0, sleep bit 1, scan-select bit 0, scan-select bit 1, port bits 0..2, segments-off and half-bias. Bits 55 and 56 must both be 0. A frame with bit 55 equal to 1 is discarded.
- R5: In the second-half frame, received bits 1..36 go to disp_o[39..74]. Bit 55 is 0 and bit 56 is 1. The first half and the control fields are left unchanged.
- R6: sleep_o is high whenever either sleep bit is 1. It returns low only after a commit that writes both sleep bits as 0.
- R7: sys_rst_o is 1 after por_n. It falls on the commit that leaves both halves received at least once since por_n, and then stays 0.
- R8: The display and control latches are not cleared by por_n. Writes committed while sys_rst_o is 1 appear on the outputs.
- R9: A read frame sends key bits 1..30 and then the sleep flag. A 1 releases the line (sdo_oe_n_o=1) and a 0 pulls it low (sdo_oe_n_o=0). Each bit is valid before the next rising serial-clock edge and advances on a falling edge that follows a rising edge. After 31 bits, and while chip enable is low, the line is released.
- R10: Writes and reads behave the same whether the serial clock rests high or low between transfers.
- R11: A read opened while sys_rst_o is 1 keeps the line released for all of its bits.
- R12: The last bit of a read equals sleep_o at the moment the read opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| por_n | input | 1 | Active-low power-up reset for framing state and the reset flag |
| ce_i | input | 1 | Chip enable from the host |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| key_bits_i | input | 30 | Key matrix state, bit 0 is key 1 |
| sdo_oe_n_o | output | 1 | Open-drain data out: 0 pulls the line low |
| disp_o | output | 75 | Latched display bits, bit 0 is the first display bit |
| sleep_sel_o | output | 2 | Sleep field {bit1, bit0} |
| scan_sel_o | output | 2 | Scan/segment select field {bit1, bit0} |
| port_sel_o | output | 3 | Port select field {bit2, bit1, bit0} |
| seg_off_o | output | 1 | Segments-off control |
| half_bias_o | output | 1 | Half-bias drive select |
| sleep_o | output | 1 | High while either sleep bit is set |
| sys_rst_o | output | 1 | Power-up reset flag for the rest of the chip |

## Verification
The hardest case to reach is the release of the reset flag. It depends on a history: both halves must have been committed since power-up, in either order. Frames that are dropped for bad length, bad half code or foreign address must not count. The bench first loads one half while the flag is still set, checks that the latches took the data but the flag stayed high, and reads keys to confirm the line stays released. Only then does it send the second half and watch the flag fall. Frames one bit short, one bit long or carrying a wrong half code are sent after that, with fresh data, to show the latches hold.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_WRITE = 8'h42;
  localparam logic [ADDR_W-1:0] ADDR_READ  = 8'h43;
  localparam int CTRL_W = 9;
  localparam int DIR_W  = 2;

  // field order matches reception order, lowest bit received first
  typedef struct packed {
    logic       half_bias;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] scan_sel;
    logic [1:0] sleep_sel;
  } ctrl_t;

  typedef enum logic [1:0] {M_IDLE, M_WRITE, M_READ, M_SKIP} mode_e;
endpackage

// File: rtl/cmdp_edge_sync.sv
module cmdp_edge_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
  end
endmodule

// File: rtl/cmdp_frame_rx.sv
module cmdp_frame_rx
  import cmdp_pkg::*;
#(
  parameter int FRAME_BITS = 56
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_i,
  input  logic                  ce_rise_i,
  input  logic                  ce_fall_i,
  input  logic                  sck_rise_i,
  input  logic                  sdi_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  commit_a_o,
  output logic                  commit_b_o,
  output logic                  read_start_o,
  output logic                  read_active_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [ADDR_W-1:0]     addr_q;
  mode_e                 mode_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] buf_q;
  logic                  len_ok, dir_a, dir_b, take_bit;

  assign take_bit = (mode_q == M_WRITE) && sck_rise_i;
  assign len_ok   = (mode_q == M_WRITE) && (cnt_q == CNT_FULL);
  assign dir_a    = ~buf_q[FRAME_BITS-2] & ~buf_q[FRAME_BITS-1];
  assign dir_b    = ~buf_q[FRAME_BITS-2] &  buf_q[FRAME_BITS-1];

  // address: shift right so the first of the last eight bits lands in bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_q <= '0;
    else if (!ce_i && sck_rise_i) addr_q <= {sdi_i, addr_q[ADDR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      cnt_q  <= '0;
    end else if (ce_rise_i) begin
      cnt_q <= '0;
      case (addr_q)
        ADDR_WRITE: mode_q <= M_WRITE;
        ADDR_READ:  mode_q <= M_READ;
        default:    mode_q <= M_SKIP;
      endcase
    end else if (ce_fall_i) begin
      mode_q <= M_IDLE;
    end else if (take_bit && cnt_q != CNT_OVER) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // holding register is not reset: content matters only with len_ok
  always_ff @(posedge clk) begin
    if (take_bit && cnt_q < CNT_FULL) buf_q[cnt_q] <= sdi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_a_o <= 1'b0;
      commit_b_o <= 1'b0;
    end else begin
      commit_a_o <= ce_fall_i & len_ok & dir_a;
      commit_b_o <= ce_fall_i & len_ok & dir_b;
    end
  end

  assign frame_o       = buf_q;
  assign read_start_o  = ce_rise_i && (addr_q == ADDR_READ);
  assign read_active_o = (mode_q == M_READ);

  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER);
  a_r1_idle_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_i && $past(!ce_i)) |-> (mode_q == M_IDLE));
  a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_a_o || commit_b_o) |-> (!ce_i && !$past(ce_i) && $past(ce_i, 2)));
endmodule

// File: rtl/cmdp_key_tx.sv
module cmdp_key_tx #(
  parameter int KEY_BITS = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                active_i,
  input  logic                sck_rise_i,
  input  logic                sck_fall_i,
  input  logic                mute_i,
  input  logic                sleep_i,
  input  logic [KEY_BITS-1:0] keys_i,
  output logic                sdo_oe_n_o
);
  localparam int OUT_BITS = KEY_BITS + 1;
  localparam int CW       = $clog2(OUT_BITS + 1);

  logic [OUT_BITS-1:0] sh_q;
  logic [CW-1:0]       left_q;
  logic                armed_q, mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
      mute_q  <= 1'b1;
    end else if (start_i) begin
      sh_q    <= {sleep_i, keys_i};
      left_q  <= CW'(OUT_BITS);
      armed_q <= 1'b0;
      mute_q  <= mute_i;
    end else if (active_i) begin
      if (sck_rise_i) armed_q <= 1'b1;
      // a fall before any rise (clock resting high) keeps bit 1 on the line
      if (sck_fall_i && armed_q && left_q != '0) begin
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign sdo_oe_n_o = ~(active_i & ~mute_q & (left_q != '0) & ~sh_q[0]);

  a_r9_advance_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != $past(left_q) && !$past(start_i)) |-> $past(sck_fall_i));
  a_r9_released_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> sdo_oe_n_o);
endmodule

// File: rtl/cmdp_image_regs.sv
module cmdp_image_regs
  import cmdp_pkg::*;
#(
  parameter int FRAME_BITS = 56,
  parameter int DISP_A     = 39,
  parameter int DISP_B     = 36
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_a_i,
  input  logic                     commit_b_i,
  input  logic [FRAME_BITS-1:0]    frame_i,
  output logic [DISP_A+DISP_B-1:0] disp_o,
  output ctrl_t                    ctrl_o,
  output logic                     sys_rst_o
);
  localparam int CTRL_LSB = FRAME_BITS - DIR_W - CTRL_W;

  logic [DISP_A+DISP_B-1:0] disp_q;
  ctrl_t                    ctrl_q;
  logic                     seen_a_q, seen_b_q, rst_q;
  logic                     unused_pad;

  assign unused_pad = ^frame_i[FRAME_BITS-1:DISP_A];

  // image and control are deliberately without reset
  always_ff @(posedge clk) begin
    if (commit_a_i) begin
      disp_q[DISP_A-1:0] <= frame_i[DISP_A-1:0];
      ctrl_q             <= ctrl_t'(frame_i[CTRL_LSB +: CTRL_W]);
    end
    if (commit_b_i) disp_q[DISP_A +: DISP_B] <= frame_i[DISP_B-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
      rst_q    <= 1'b1;
    end else begin
      if (commit_a_i) seen_a_q <= 1'b1;
      if (commit_b_i) seen_b_q <= 1'b1;
      if ((commit_a_i || commit_b_i) && (seen_a_q || commit_a_i) && (seen_b_q || commit_b_i))
        rst_q <= 1'b0;
    end
  end

  assign disp_o    = disp_q;
  assign ctrl_o    = ctrl_q;
  assign sys_rst_o = rst_q;

  a_r7_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |=> !rst_q);
  a_r7_release_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> (seen_a_q && seen_b_q && $past(commit_a_i || commit_b_i)));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import cmdp_pkg::*;
#(
  parameter int DISP_A_BITS = 39,
  parameter int DISP_B_BITS = 36,
  parameter int PAD_A_BITS  = 6,
  parameter int KEY_BITS    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic                           ce_i,
  input  logic                           sck_i,
  input  logic                           sdi_i,
  input  logic [KEY_BITS-1:0]            key_bits_i,
  output logic                           sdo_oe_n_o,
  output logic [DISP_A_BITS+DISP_B_BITS-1:0] disp_o,
  output logic [1:0]                     sleep_sel_o,
  output logic [1:0]                     scan_sel_o,
  output logic [2:0]                     port_sel_o,
  output logic                           seg_off_o,
  output logic                           half_bias_o,
  output logic                           sleep_o,
  output logic                           sys_rst_o
);
  localparam int FRAME_BITS = DISP_A_BITS + PAD_A_BITS + CTRL_W + DIR_W;

  logic [1:0] lvl, rise, fall;
  logic [SYNC_STAGES-1:0] sdi_sh;
  logic sdi_lvl;
  logic [FRAME_BITS-1:0] frame;
  logic commit_a, commit_b, rd_start, rd_active;
  ctrl_t ctrl;

  // line 0 is chip enable, line 1 the serial clock
  cmdp_edge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d_i({sck_i, ce_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  // data path gets the same depth so it lines up with the clock edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sdi_sh <= '0;
    else        sdi_sh <= {sdi_sh[SYNC_STAGES-2:0], sdi_i};
  end
  assign sdi_lvl = sdi_sh[SYNC_STAGES-1];

  cmdp_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(por_n), .ce_i(lvl[0]), .ce_rise_i(rise[0]),
    .ce_fall_i(fall[0]), .sck_rise_i(rise[1]), .sdi_i(sdi_lvl),
    .frame_o(frame), .commit_a_o(commit_a), .commit_b_o(commit_b),
    .read_start_o(rd_start), .read_active_o(rd_active)
  );

  cmdp_image_regs #(.FRAME_BITS(FRAME_BITS), .DISP_A(DISP_A_BITS), .DISP_B(DISP_B_BITS)) u_img (
    .clk(clk), .rst_n(por_n), .commit_a_i(commit_a), .commit_b_i(commit_b),
    .frame_i(frame), .disp_o(disp_o), .ctrl_o(ctrl), .sys_rst_o(sys_rst_o)
  );

  cmdp_key_tx #(.KEY_BITS(KEY_BITS)) u_tx (
    .clk(clk), .rst_n(por_n), .start_i(rd_start), .active_i(rd_active),
    .sck_rise_i(rise[1]), .sck_fall_i(fall[1]), .mute_i(sys_rst_o),
    .sleep_i(sleep_o), .keys_i(key_bits_i), .sdo_oe_n_o(sdo_oe_n_o)
  );

  assign sleep_sel_o = ctrl.sleep_sel;
  assign scan_sel_o  = ctrl.scan_sel;
  assign port_sel_o  = ctrl.port_sel;
  assign seg_off_o   = ctrl.seg_off;
  assign half_bias_o = ctrl.half_bias;
  assign sleep_o     = |ctrl.sleep_sel;

  a_r2_one_half_per_commit: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({commit_a, commit_b}));
  a_r2_no_drive_outside_read: assert property (@(posedge clk) disable iff (!por_n)
    !sdo_oe_n_o |-> rd_active);
endmodule

// File: tb/serial_cmd_port_tb_top.sv
module serial_cmd_port_tb_top;
  localparam int H = 6;
  logic clk = 1'b0, por_n = 1'b0, ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [29:0] keys = '0;
  logic sdo;
  logic [74:0] disp;
  logic [1:0] sleep_sel, scan_sel;
  logic [2:0] port_sel;
  logic seg_off, half_bias, sleep, sys_rst;
  int n_chk = 0, n_bad = 0;
  bit idle_hi = 1'b0;

  serial_cmd_port dut_i (
    .clk(clk), .por_n(por_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
    .key_bits_i(keys), .sdo_oe_n_o(sdo), .disp_o(disp),
    .sleep_sel_o(sleep_sel), .scan_sel_o(scan_sel), .port_sel_o(port_sel),
    .seg_off_o(seg_off), .half_bias_o(half_bias), .sleep_o(sleep), .sys_rst_o(sys_rst)
  );

  always #10 clk = ~clk;

  task automatic wait_h();
    repeat (H) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one bit; returns data-out sampled just before the rising edge
  task automatic clk_bit(input logic b, output logic smp);
    if (idle_hi) begin
      sck = 1'b0; sdi = b; wait_h(); smp = sdo; sck = 1'b1; wait_h();
    end else begin
      sdi = b; wait_h(); smp = sdo; sck = 1'b1; wait_h(); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [3:0] lead, input int nlead,
                      input logic [63:0] bits, input int n, output logic [63:0] got);
    logic s;
    got = '1;
    sck = idle_hi; ce = 1'b0; wait_h();
    for (int i = 0; i < nlead; i++) clk_bit(lead[i], s);
    for (int i = 0; i < 8; i++) clk_bit(a[i], s);
    wait_h(); ce = 1'b1; wait_h();
    for (int i = 0; i < n; i++) begin clk_bit(bits[i], s); got[i] = s; end
    wait_h(); ce = 1'b0; wait_h(); wait_h();
  endtask

  // dir = {bit 56, bit 55}
  function automatic logic [63:0] fa(input logic [38:0] d, input logic [8:0] c, input logic [1:0] dir);
    logic [63:0] r = '0;
    r[38:0] = d; r[53:45] = c; r[54] = dir[0]; r[55] = dir[1];
    return r;
  endfunction

  function automatic logic [63:0] fb(input logic [35:0] d);
    logic [63:0] r = '0;
    r[35:0] = d; r[55] = 1'b1;
    return r;
  endfunction

  logic [63:0] g;
  localparam logic [38:0] DA1 = 39'h5A_1234_5678;
  localparam logic [38:0] DA2 = 39'h21_0F0F_F0F0;
  localparam logic [38:0] DA3 = 39'h7F_FFFF_0001;
  localparam logic [35:0] DB1 = 36'hC_3C3C_A5A5;
  localparam logic [8:0]  C1  = 9'b010111000; // S0=0 S1=0 K0=0 K1=1 P=011 SC=1 DR=0

  task automatic t_reset();
    chk("R7", "flag after por", sys_rst, 1);
    chk("R9", "line idle", sdo, 1);
  endtask

  task automatic t_write_a_in_reset();
    xfer(8'h42, 4'h0, 0, fa(DA1, C1, 2'b00), 56, g);
    chk("R4", "first half", disp[38:0], DA1);
    chk("R4", "control fields", {half_bias, seg_off, port_sel, scan_sel, sleep_sel}, {1'b0, 1'b1, 3'b011, 2'b10, 2'b00});
    chk("R8", "write during reset landed", sleep, 0);
    chk("R7", "flag held with one half", sys_rst, 1);
  endtask

  task automatic t_read_in_reset();
    keys = 30'h2AAA_5555;
    xfer(8'h43, 4'h0, 0, '0, 31, g);
    chk("R11", "muted read", g[30:0], 31'h7FFF_FFFF);
  endtask

  task automatic t_write_b();
    xfer(8'h42, 4'h0, 0, fb(DB1), 56, g);
    chk("R5", "second half", disp[74:39], DB1);
    chk("R5", "first half kept", disp[38:0], DA1);
    chk("R7", "flag released", sys_rst, 0);
  endtask

  task automatic t_read_normal(input logic [29:0] k, input logic sa, input string tag);
    keys = k;
    xfer(8'h43, 4'h0, 0, '0, 31, g);
    chk("R9", {"key bits ", tag}, g[29:0], k);
    chk("R12", {"sleep ack ", tag}, g[30], sa);
    chk("R9", {"released after ", tag}, sdo, 1);
  endtask

  task automatic t_addr_lead();
    xfer(8'h42, 4'b1101, 4, fa(DA2, C1, 2'b00), 56, g);
    chk("R1", "last eight address bits", disp[38:0], DA2);
  endtask

  task automatic t_bad_addr();
    xfer(8'h44, 4'h0, 0, fa(DA3, C1, 2'b00), 56, g);
    chk("R2", "foreign address ignored", disp[38:0], DA2);
    keys = '0;
    xfer(8'hC2, 4'h0, 0, '0, 31, g);
    chk("R2", "foreign read keeps line released", g[30:0], 31'h7FFF_FFFF);
  endtask

  task automatic t_length();
    xfer(8'h42, 4'h0, 0, fa(DA3, C1, 2'b00), 55, g);
    chk("R3", "short frame dropped", disp[38:0], DA2);
    xfer(8'h42, 4'h0, 0, fa(DA3, C1, 2'b00), 57, g);
    chk("R3", "long frame dropped", disp[38:0], DA2);
  endtask

  task automatic t_bad_dir();
    xfer(8'h42, 4'h0, 0, fa(DA3, C1, 2'b01), 56, g);
    chk("R4", "bad half code dropped", disp[38:0], DA2);
  endtask

  task automatic t_sleep();
    xfer(8'h42, 4'h0, 0, fa(DA2, 9'b010111010, 2'b00), 56, g);
    chk("R6", "sleep via bit 1", sleep, 1);
    t_read_normal(30'h0000_00FF, 1'b1, "asleep");
    xfer(8'h42, 4'h0, 0, fa(DA2, 9'b010111001, 2'b00), 56, g);
    chk("R6", "sleep via bit 0", sleep, 1);
    xfer(8'h42, 4'h0, 0, fa(DA2, C1, 2'b00), 56, g);
    chk("R6", "sleep cleared", sleep, 0);
  endtask

  task automatic t_idle_high();
    idle_hi = 1'b1;
    xfer(8'h42, 4'h0, 0, fa(DA3, 9'b101000100, 2'b00), 56, g);
    chk("R10", "first half idle high", disp[38:0], DA3);
    chk("R10", "control idle high", {half_bias, seg_off, port_sel, scan_sel, sleep_sel}, {1'b1, 1'b0, 3'b100, 2'b01, 2'b00});
    xfer(8'h42, 4'h0, 0, fb(36'h5_6789_ABCD), 56, g);
    chk("R10", "second half idle high", disp[74:39], 36'h5_6789_ABCD);
    t_read_normal(30'h1357_9BDF, 1'b0, "idle high");
    idle_hi = 1'b0;
    sck = 1'b0; wait_h();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); por_n = 1'b1;
    wait_h();
    t_reset();
    t_write_a_in_reset();
    t_read_in_reset();
    t_write_b();
    t_read_normal(30'h1234_5678, 1'b0, "normal");
    t_addr_lead();
    t_bad_addr();
    t_length();
    t_bad_dir();
    t_sleep();
    t_idle_high();
    summary();
  end
endmodule